// File: doc/BRIEF.md
# Output-Compare Timer Channel

This block is a 16-bit up-counting timer channel with four compare registers, A to D, and four compare output pins, one for each register. The counter advances once on every cycle where the channel is running and the prescaled count strobe `srcTick` is high. A compare match happens on a counting tick where the counter equals a compare register. The matching pin then takes the action chosen for it (drive low, drive high or invert), and the new level appears after the next clock edge. Software programs the channel through a simple register port. Writes are single-cycle strobes and reads are combinational.

The counter can run free over its full 65536-tick period. It can instead return to zero on a match with register A or with register B, which gives a period of n+1 ticks. In stop-on-match mode the channel halts by itself on a match with register A. Registers C and D can be redirected so that each acts as a second match point for pin A or pin B. The overflow event and each of the four match events set sticky status flags. Writing 1 to a flag clears it. `irq` is raised while any enabled flag is set.

Register map (4-bit address): 0 control (bit0 run, bit1 stop-on-match-A, bits4:2 clear select); 1 pin configuration (4 bits per pin, pin p at bits 4p+3:4p: bit0 output enable, bit1 initial level, bits3:2 action 00 none, 01 low, 10 high, 11 invert); 2 redirect (bit0 register C drives pin A, bit1 register D drives pin B); 3 status (bit0 overflow, bits1..4 match A..D, write 1 to clear); 4 interrupt enable (same bit layout as status); 5 counter; 8..11 compare registers A..D.

Top module: `cmp_timer_chan`

## Requirements
- R1: While running, the counter increments by one on each cycle with `srcTick` high and holds on the other cycles. In free-running mode it wraps from FFFFh to 0000h.
- R2: Clear select bits1:0 equal to 01 return the counter to 0000h on the tick that matches register A, and 10 does the same for register B, giving a period of n+1 ticks. Codes 00 and 11 run freely. Bit2 of the field is stored but has no effect.
- R3: Writing 1 to the run bit starts counting. Writing 0 stops the counter, and the counter and all pin levels then hold.
- R4: When stop-on-match is set, a match with register A clears the run bit and leaves the counter at the matched value. The pins keep the levels set by that match.
- R5: On a match, each pin applies its own 2-bit action: 01 drives 0, 10 drives 1, 11 inverts the current level, and 00 leaves the level unchanged. The new level shows after the clock edge that ends the matching tick.
- R6: A start write made while stopped (other than after a stop-on-match halt) loads each pin's initial level. That level holds until the pin's first match.
- R7: A start write after a stop-on-match halt resumes counting from the held counter value and does not reload the initial levels.
- R8: `pinOe[p]` follows pin p's enable bit. A disabled pin drives `pinOut[p]` low.
- R9: With redirect bit0 set, a match on register C applies pin A's action to pin A, and pin C no longer changes. Redirect bit1 does the same with register D and pin B.
- R10: Status flags are sticky, each set by its own event and cleared by writing 1 to its bit. An event on the same cycle as a clearing write leaves the flag set.
- R11: `irq` is high exactly while some status flag is set whose interrupt-enable bit is also set.
- R12: A counter write takes effect on the next edge in place of any tick on that cycle, and the counter register always reads the live count.
- R13: After reset the channel is stopped, the counter is 0000h, the compare registers are FFFFh, all pins are disabled and the status is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcTick | input | 1 | Prescaled count strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| pinOut | output | 4 | Compare output levels for pins A..D |
| pinOe | output | 4 | Compare output enables for pins A..D |
| irq | output | 1 | Interrupt request |

## Verification
The clear-on-match path is swept over several compare values, once with register A and once with register B. The register B case uses a clear code whose unused high bit is set. Tracking the count and a toggling pin over three full periods separates an off-by-one period from a wrong clear source. Every action is tried against both initial levels on a free-running counter, which tells a wrong action code from a wrong initial load. Separate sequences cover four further behaviours:
- redirection, where a second match must move pin A while pin C stays still;
- a stop-on-match halt followed by a restart, compared with a restart after an ordinary stop;
- an overflow with its interrupt masked and then unmasked;
- a counter write followed by a sparse strobe pattern.

// File: rtl/cmptim_pkg.sv
package cmptim_pkg;
  localparam int CNT_W     = 16;
  localparam int NUM_CMP   = 4;
  localparam int ADDR_W    = 4;
  localparam int PIN_CFG_W = 4;
  localparam int STAT_W    = NUM_CMP + 1;

  typedef logic [ADDR_W-1:0] addrT;

  localparam addrT A_CTRL   = 4'd0;
  localparam addrT A_PINCFG = 4'd1;
  localparam addrT A_REDIR  = 4'd2;
  localparam addrT A_STATUS = 4'd3;
  localparam addrT A_IRQEN  = 4'd4;
  localparam addrT A_COUNT  = 4'd5;
  localparam addrT A_GR0    = 4'd8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } actT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInit;
    logic cntWr;
  } cmdT;

  // events from datapath to control
  typedef struct packed {
    logic               ovf;
    logic [NUM_CMP-1:0] match;
    logic               halt;
  } evtT;
endpackage

// File: rtl/cmptim_ctrl.sv
module cmptim_ctrl
  import cmptim_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  addrT                             wrAddr,
  input  logic [CW-1:0]                    wrData,
  input  addrT                             rdAddr,
  output logic [CW-1:0]                    rdData,
  input  logic [CW-1:0]                    cntVal,
  input  evtT                              evt,
  output cmdT                              cmd,
  output logic                             runBit,
  output logic                             stopMode,
  output logic [1:0]                       clrSelLo,
  output logic [NUM_CMP*PIN_CFG_W-1:0]     pinCfg,
  output logic [1:0]                       redir,
  output logic [NUM_CMP-1:0][CW-1:0]       grVal,
  output logic [STAT_W-1:0]                statusVal,
  output logic [STAT_W-1:0]                irqEnVal
);
  localparam int PCFG_W = NUM_CMP * PIN_CFG_W;

  logic [2:0] clrSelQ;
  logic       haltedQ;
  logic       wrCtrl, wrStatus;
  logic [STAT_W-1:0] w1c, evBits;

  assign wrCtrl   = wrEn && (wrAddr == A_CTRL);
  assign wrStatus = wrEn && (wrAddr == A_STATUS);
  assign w1c      = wrStatus ? wrData[STAT_W-1:0] : '0;
  assign evBits   = {evt.match, evt.ovf};

  assign cmd.cntWr    = wrEn && (wrAddr == A_COUNT);
  assign cmd.loadInit = wrCtrl && wrData[0] && !runBit && !haltedQ;
  assign clrSelLo     = clrSelQ[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      stopMode <= 1'b0;
      clrSelQ  <= 3'b000;
      haltedQ  <= 1'b0;
    end else if (wrCtrl) begin
      runBit   <= wrData[0];
      stopMode <= wrData[1];
      clrSelQ  <= wrData[4:2];
      if (wrData[0]) haltedQ <= 1'b0;
    end else if (evt.halt) begin
      runBit  <= 1'b0;
      haltedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinCfg    <= '0;
      redir     <= 2'b00;
      irqEnVal  <= '0;
      statusVal <= '0;
    end else begin
      if (wrEn && wrAddr == A_PINCFG) pinCfg   <= wrData[PCFG_W-1:0];
      if (wrEn && wrAddr == A_REDIR)  redir    <= wrData[1:0];
      if (wrEn && wrAddr == A_IRQEN)  irqEnVal <= wrData[STAT_W-1:0];
      statusVal <= (statusVal & ~w1c) | evBits;
    end
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_gr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         grVal[gi] <= '1;
      else if (wrEn && wrAddr == addrT'(A_GR0 + gi))     grVal[gi] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:   rdData[4:0]          = {clrSelQ, stopMode, runBit};
      A_PINCFG: rdData[PCFG_W-1:0]   = pinCfg;
      A_REDIR:  rdData[1:0]          = redir;
      A_STATUS: rdData[STAT_W-1:0]   = statusVal;
      A_IRQEN:  rdData[STAT_W-1:0]   = irqEnVal;
      A_COUNT:  rdData               = cntVal;
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (rdAddr == addrT'(A_GR0 + i)) rdData = grVal[i];
      end
    endcase
  end
endmodule

// File: rtl/cmptim_dp.sv
module cmptim_dp
  import cmptim_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         srcTick,
  input  logic                         runBit,
  input  logic                         stopMode,
  input  logic [1:0]                   clrSelLo,
  input  logic [NUM_CMP*PIN_CFG_W-1:0] pinCfg,
  input  logic [1:0]                   redir,
  input  logic [NUM_CMP-1:0][CW-1:0]   grVal,
  input  cmdT                          cmd,
  input  logic [CW-1:0]                wrData,
  output logic [CW-1:0]                cntVal,
  output logic [NUM_CMP-1:0]           pinOut,
  output logic [NUM_CMP-1:0]           pinOe,
  output evtT                          evt
);
  logic               tick, clearHit, haltHit, ovfHit;
  logic [NUM_CMP-1:0] hit, pinEv;

  // a counter write replaces the tick of that cycle
  assign tick = runBit && srcTick && !cmd.cntWr;

  for (genvar ci = 0; ci < NUM_CMP; ci++) begin : g_cmp
    assign hit[ci] = tick && (cntVal == grVal[ci]);
  end

  assign clearHit = (clrSelLo == 2'b01 && hit[0]) || (clrSelLo == 2'b10 && hit[1]);
  assign haltHit  = stopMode && hit[0];
  assign ovfHit   = tick && (cntVal == {CW{1'b1}}) && !clearHit && !haltHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (cmd.cntWr)    cntVal <= wrData;
    else if (tick) begin
      if (clearHit)        cntVal <= '0;
      else if (!haltHit)   cntVal <= cntVal + 1'b1;
    end
  end

  // routing of match events onto pins
  assign pinEv[0] = hit[0] | (redir[0] & hit[2]);
  assign pinEv[1] = hit[1] | (redir[1] & hit[3]);
  assign pinEv[2] = hit[2] & ~redir[0];
  assign pinEv[3] = hit[3] & ~redir[1];

  for (genvar p = 0; p < NUM_CMP; p++) begin : g_pin
    logic en, initLvl, lvlQ;
    actT  act;
    assign en      = pinCfg[p*PIN_CFG_W];
    assign initLvl = pinCfg[p*PIN_CFG_W+1];
    assign act     = actT'(pinCfg[p*PIN_CFG_W+2 +: 2]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             lvlQ <= 1'b0;
      else if (cmd.loadInit) lvlQ <= initLvl;
      else if (pinEv[p]) begin
        case (act)
          ACT_LOW:    lvlQ <= 1'b0;
          ACT_HIGH:   lvlQ <= 1'b1;
          ACT_TOGGLE: lvlQ <= ~lvlQ;
          default:    lvlQ <= lvlQ;
        endcase
      end
    end

    assign pinOe[p]  = en;
    assign pinOut[p] = en & lvlQ;
  end

  assign evt.ovf   = ovfHit;
  assign evt.match = hit;
  assign evt.halt  = haltHit;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmptim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcTick,
  input  logic         wrEn,
  input  logic [3:0]   wrAddr,
  input  logic [15:0]  wrData,
  input  logic [3:0]   rdAddr,
  output logic [15:0]  rdData,
  output logic [3:0]   pinOut,
  output logic [3:0]   pinOe,
  output logic         irq
);
  cmdT                               cmd;
  evtT                               evt;
  logic                              runBit, stopMode;
  logic [1:0]                        clrSelLo, redir;
  logic [NUM_CMP*PIN_CFG_W-1:0]      pinCfg;
  logic [NUM_CMP-1:0][CNT_W-1:0]     grVal;
  logic [CNT_W-1:0]                  cntVal;
  logic [STAT_W-1:0]                 statusVal, irqEnVal;

  cmptim_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntVal(cntVal), .evt(evt), .cmd(cmd),
    .runBit(runBit), .stopMode(stopMode), .clrSelLo(clrSelLo), .pinCfg(pinCfg),
    .redir(redir), .grVal(grVal), .statusVal(statusVal), .irqEnVal(irqEnVal)
  );

  cmptim_dp #(.CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .runBit(runBit),
    .stopMode(stopMode), .clrSelLo(clrSelLo), .pinCfg(pinCfg), .redir(redir),
    .grVal(grVal), .cmd(cmd), .wrData(wrData), .cntVal(cntVal),
    .pinOut(pinOut), .pinOe(pinOe), .evt(evt)
  );

  assign irq = |(statusVal & irqEnVal);
endmodule

// File: rtl/cmptim_chk.sv
module cmptim_chk
  import cmptim_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               srcTick,
  input logic               wrEn,
  input addrT               wrAddr,
  input logic [STAT_W-1:0]  wrLow,
  input logic               runBit,
  input logic [CNT_W-1:0]   cntVal,
  input logic [CNT_W-1:0]   graVal,
  input logic [CNT_W-1:0]   grbVal,
  input logic [STAT_W-1:0]  statusVal,
  input logic [STAT_W-1:0]  irqEnVal,
  input logic               irq,
  input logic [NUM_CMP-1:0] pinOut,
  input logic [NUM_CMP-1:0] pinOe
);
  logic [STAT_W-1:0] prevStatus, prevClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStatus <= '0;
      prevClr    <= '0;
    end else begin
      prevStatus <= statusVal;
      prevClr    <= (wrEn && wrAddr == A_STATUS) ? wrLow : '0;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && srcTick && !(wrEn && wrAddr == A_COUNT) && cntVal != graVal && cntVal != grbVal)
      |=> cntVal == CNT_W'($past(cntVal) + 1'b1));

  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !(wrEn && wrAddr == A_COUNT)) |=> $stable(cntVal));

  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !(wrEn && (wrAddr == A_CTRL || wrAddr == A_PINCFG))) |=> $stable(pinOut));

  assert_oe_only_by_cfg_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == A_PINCFG) |=> $stable(pinOe));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((prevStatus & ~prevClr) & ~statusVal) == '0);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statusVal & irqEnVal) != '0));
endmodule

bind cmp_timer_chan cmptim_chk u_chk (
  .clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrLow(wrData[cmptim_pkg::STAT_W-1:0]), .runBit(runBit), .cntVal(cntVal),
  .graVal(grVal[0]), .grbVal(grVal[1]), .statusVal(statusVal),
  .irqEnVal(irqEnVal), .irq(irq), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/tb_cmp_timer_chan.sv
module tb_cmp_timer_chan;
  import cmptim_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0, srcTick = 1'b1, wrEn = 1'b0;
  logic [3:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  wire  [15:0] rdData;
  wire  [3:0]  pinOut, pinOe;
  wire         irq;

  int checks = 0, fails = 0, phase = 0;
  bit done = 0, tickDiv = 0;

  cmp_timer_chan dut (.clk(clk), .rstN(rstN), .srcTick(srcTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // strobe pattern: every cycle, or one in three
  always @(negedge clk) begin
    if (tickDiv) begin
      srcTick <= (phase == 0);
      phase   <= (phase == 2) ? 0 : phase + 1;
    end else srcTick <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  initial begin
    logic [15:0] v, v0;
    int n, expLvl;
    int nList[4] = '{1, 2, 3, 5};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    rd(A_COUNT, v);  chk("R13 count", v, 0);
    rd(A_CTRL, v);   chk("R13 ctrl", v, 0);
    rd(A_GR0, v);    chk("R13 compare A", v, 16'hFFFF);
    rd(A_STATUS, v); chk("R13 status", v, 0);
    chk("R13 pinOe", pinOe, 0);
    chk("R13 irq", irq, 0);

    // R2/R5: clear on A (code 001) or on B (code 110, bit2 ignored), toggle pin
    for (int s = 0; s < 2; s++) begin
      for (int ni = 0; ni < 4; ni++) begin
        n = nList[ni];
        wr(A_CTRL, 16'h0);
        wr(A_COUNT, 16'h0);
        wr(A_STATUS, 16'h1F);
        wr(A_GR0, (s == 0) ? 16'(n) : 16'hFFF0);
        wr(4'(A_GR0 + 1), (s == 0) ? 16'hFFF0 : 16'(n));
        wr(A_PINCFG, (s == 0) ? 16'h000D : 16'h00D0);
        wr(A_CTRL, (s == 0) ? 16'h0005 : 16'h0019);
        for (int k = 1; k <= 3 * (n + 1); k++) begin
          @(negedge clk);
          rd(A_COUNT, v);
          chk("R2 period count", v, 32'(k % (n + 1)));
          chk("R5 toggle level", pinOut[s], 32'((k / (n + 1)) % 2));
        end
      end
    end

    // R5/R6: every action against both initial levels on pin B, free-running
    for (int a = 1; a <= 3; a++) begin
      for (int il = 0; il < 2; il++) begin
        wr(A_CTRL, 16'h0);
        wr(A_COUNT, 16'h0);
        wr(A_GR0, 16'hFFF0);
        wr(4'(A_GR0 + 1), 16'd3);
        wr(A_PINCFG, 16'(((a << 2) | (il << 1) | 1) << 4));
        wr(A_CTRL, 16'h0001);
        repeat (3) @(negedge clk);
        chk("R6 initial level", pinOut[1], 32'(il));
        @(negedge clk);
        expLvl = (a == 1) ? 0 : (a == 2) ? 1 : 1 - il;
        chk("R5 action", pinOut[1], 32'(expLvl));
        rd(A_COUNT, v);
        chk("R2 free-run no clear", v, 4);
      end
    end

    // R9: register C as second match point on pin A
    wr(A_CTRL, 16'h0);
    wr(A_COUNT, 16'h0);
    wr(A_STATUS, 16'h1F);
    wr(A_GR0, 16'd2);
    wr(4'(A_GR0 + 1), 16'hFFF0);
    wr(4'(A_GR0 + 2), 16'd5);
    wr(4'(A_GR0 + 3), 16'hFFF0);
    wr(A_REDIR, 16'h0001);
    wr(A_PINCFG, 16'h0F0D);
    wr(A_CTRL, 16'h0001);
    chk("R8 enables", pinOe, 4'b0101);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R9 pin A two match points", pinOut[0], 32'((k >= 3 && k < 6) ? 1 : 0));
      chk("R9 pin C held", pinOut[2], 1);
    end
    rd(A_STATUS, v);
    chk("R10 match flags A and C", v & 16'h1E, 16'h0A);

    // R4/R7: stop on match A, then restart
    wr(A_CTRL, 16'h0);
    wr(A_REDIR, 16'h0);
    wr(A_COUNT, 16'h0);
    wr(4'(A_GR0 + 2), 16'hFFF0);
    wr(A_GR0, 16'd4);
    wr(A_PINCFG, 16'h0009);
    wr(A_CTRL, 16'h0003);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v);  chk("R4 halted count", v, 4);
    chk("R4 level after final match", pinOut[0], 1);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v);  chk("R4 count stays", v, 4);
    rd(A_CTRL, v);   chk("R4 run bit cleared", v[0], 0);
    wr(A_CTRL, 16'h0001);
    chk("R7 no initial reload", pinOut[0], 1);
    rd(A_COUNT, v);  chk("R7 count held at restart", v, 4);
    @(negedge clk);
    rd(A_COUNT, v);  chk("R7 resumes from held value", v, 5);

    // R3: stop by write holds counter and pins, R6: plain restart reloads
    wr(A_CTRL, 16'h0);
    rd(A_COUNT, v0);
    repeat (4) @(negedge clk);
    rd(A_COUNT, v);  chk("R3 counter holds", v, v0);
    chk("R3 pin holds", pinOut[0], 1);
    wr(A_CTRL, 16'h0001);
    chk("R6 reload after plain stop", pinOut[0], 0);
    wr(A_CTRL, 16'h0);

    // R8/R1/R10/R11: overflow with interrupt masking
    wr(A_PINCFG, 16'h0);
    chk("R8 disabled oe", pinOe, 0);
    chk("R8 disabled out", pinOut, 0);
    for (int i = 0; i < 4; i++) wr(4'(A_GR0 + i), 16'h8000);
    wr(A_STATUS, 16'h1F);
    wr(A_IRQEN, 16'h0);
    wr(A_COUNT, 16'hFFFE);
    wr(A_CTRL, 16'h0001);
    @(negedge clk);
    @(negedge clk);
    rd(A_COUNT, v);  chk("R1 wrap to zero", v, 0);
    rd(A_STATUS, v); chk("R10 overflow flag", v, 16'h0001);
    chk("R11 masked irq", irq, 0);
    wr(A_IRQEN, 16'h0001);
    chk("R11 enabled irq", irq, 1);
    wr(A_STATUS, 16'h0001);
    chk("R11 irq after clear", irq, 0);
    rd(A_STATUS, v); chk("R10 write one clears", v, 0);

    // R12/R1: counter write while running, then one-in-three strobe
    tickDiv = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_COUNT, 16'd100);
    rd(A_COUNT, v);  chk("R12 written count", v, 100);
    repeat (9) @(negedge clk);
    rd(A_COUNT, v);  chk("R1 gated by strobe", v, 103);
    tickDiv = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual still running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule